// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit CPU and the memories of a banked system with a 16-bit address bus. For every address it selects exactly one memory region. The regions are a boot ROM overlay, a fixed ROM bank, a switchable ROM window, video RAM, a switchable external RAM window, work RAM and its echo, object attribute RAM, an unusable hole, the I/O register page and high RAM. The block produces a one-hot select, the local offset inside the region, the bank number for banked regions and per-region write strobes. It also routes the read data of the selected region back to the CPU.

Decoding is combinational. The only state is a latch that enables the boot ROM overlay. Reset enables the overlay. A CPU write to address 0xFF50 turns the overlay off, and it stays off until the next reset. The ROM and RAM bank numbers come from an external bank controller and are passed through as inputs.

Top module: `mem_map_decoder`

## Requirements
- R1: While the boot overlay is enabled, addresses 0x0000–0x00FF select the boot ROM (sel bit 0) with offset equal to the low 8 address bits.
- R2: Addresses 0x0000–0x3FFF that the overlay does not claim select fixed ROM (sel bit 1), with offset = address and rom_bank_o = 0.
- R3: Addresses 0x4000–0x7FFF select the switchable ROM window (sel bit 2), with offset = address − 0x4000. rom_bank_o equals rom_bank_i, except that a request for bank 0 gives bank 1.
- R4: Addresses 0x8000–0x9FFF select video RAM (sel bit 3) with offset = address − 0x8000. Addresses 0xA000–0xBFFF select external RAM (sel bit 4) with offset = address − 0xA000 and ram_bank_o = ram_bank_i. ram_bank_o is 0 for every other region.
- R5: Addresses 0xC000–0xDFFF select work RAM (sel bit 5) with offset = address − 0xC000. Addresses 0xE000–0xFDFF select the same work RAM with offset = address − 0xE000.
- R6: Addresses 0xFE00–0xFE9F select object attribute RAM (sel bit 6) with offset = address − 0xFE00. Addresses 0xFEA0–0xFEFF select the hole (sel bit 7), where offset is 0 and rdata_o is 0x00.
- R7: Addresses 0xFF00–0xFF7F select the I/O page (sel bit 8) with offset = address − 0xFF00. Addresses 0xFF80–0xFFFF select high RAM (sel bit 9) with offset = address − 0xFF80.
- R8: Reset enables the boot overlay (boot_en_o = 1). A write to 0xFF50 clears it from the next clock edge, and no later access sets it again before reset. A write to any other address leaves it unchanged.
- R9: For every address, exactly one bit of sel_o is set.
- R10: we_o equals sel_o when wr_en_i is high and the selected region is writable. The boot ROM, both ROM regions and the hole are never writable, so their write strobes stay low.
- R11: rdata_o carries the read data input of the selected region. Both ROM regions return rom_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wr_en_i | input | 1 | CPU write cycle |
| rom_bank_i | input | ROM_BANK_W | Requested switchable ROM bank |
| ram_bank_i | input | RAM_BANK_W | Requested external RAM bank |
| boot_rdata_i | input | DATA_W | Boot ROM read data |
| rom_rdata_i | input | DATA_W | Game ROM read data |
| vram_rdata_i | input | DATA_W | Video RAM read data |
| xram_rdata_i | input | DATA_W | External RAM read data |
| wram_rdata_i | input | DATA_W | Work RAM read data |
| oam_rdata_i | input | DATA_W | Object attribute RAM read data |
| io_rdata_i | input | DATA_W | I/O page read data |
| hram_rdata_i | input | DATA_W | High RAM read data |
| sel_o | output | 10 | One-hot region select |
| we_o | output | 10 | Per-region write strobe |
| offset_o | output | 14 | Offset inside the region |
| rom_bank_o | output | ROM_BANK_W | Effective ROM bank of the access |
| ram_bank_o | output | RAM_BANK_W | Effective RAM bank of the access |
| rdata_o | output | DATA_W | Read data to the CPU |
| boot_en_o | output | 1 | Boot overlay enabled |

## Verification
The hardest case to reach is the boot latch, because it changes the decode of the lowest 256 bytes only on the clock edge after a write to one exact address. The driver first checks the overlay right after reset. It then writes to the neighbouring address 0xFF4F and shows that low addresses still decode to boot ROM. Next it writes 0xFF50 and samples the same addresses after the edge. A second write to 0xFF50 and a mid-run reset confirm that the latch is one-way and that reset restores the overlay. Region edges are exercised at both ends of each window, and bank 0 is requested in the switchable ROM window.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned OFFS_W      = 14;
  localparam int unsigned NUM_REGIONS = 10;

  localparam int unsigned RG_BOOT = 0;
  localparam int unsigned RG_ROM0 = 1;
  localparam int unsigned RG_ROMX = 2;
  localparam int unsigned RG_VRAM = 3;
  localparam int unsigned RG_XRAM = 4;
  localparam int unsigned RG_WRAM = 5;
  localparam int unsigned RG_OAM  = 6;
  localparam int unsigned RG_HOLE = 7;
  localparam int unsigned RG_IO   = 8;
  localparam int unsigned RG_HRAM = 9;

  localparam logic [ADDR_W-1:0] OAM_BASE  = 16'hFE00;
  localparam logic [ADDR_W-1:0] HOLE_BASE = 16'hFEA0;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'hFF00;
  localparam logic [ADDR_W-1:0] HRAM_BASE = 16'hFF80;
  localparam logic [ADDR_W-1:0] BOOT_OFF  = 16'hFF50;

  // regions that accept CPU writes
  localparam logic [NUM_REGIONS-1:0] WRITABLE =
    NUM_REGIONS'((1 << RG_VRAM) | (1 << RG_XRAM) | (1 << RG_WRAM) |
                 (1 << RG_OAM)  | (1 << RG_IO)   | (1 << RG_HRAM));
endpackage

// File: rtl/mmd_region_dec.sv
module mmd_region_dec
  import mmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_en_i,
  output logic [3:0]        region_o,
  output logic [OFFS_W-1:0] offset_o
);
  always_comb begin
    region_o = 4'(RG_HRAM);
    offset_o = '0;
    if (boot_en_i && addr_i[15:8] == 8'h00) begin
      region_o = 4'(RG_BOOT);
      offset_o = OFFS_W'(addr_i[7:0]);
    end else if (addr_i[15:14] == 2'b00) begin
      region_o = 4'(RG_ROM0);
      offset_o = addr_i[13:0];
    end else if (addr_i[15:14] == 2'b01) begin
      region_o = 4'(RG_ROMX);
      offset_o = addr_i[13:0];
    end else if (addr_i[15:13] == 3'b100) begin
      region_o = 4'(RG_VRAM);
      offset_o = OFFS_W'(addr_i[12:0]);
    end else if (addr_i[15:13] == 3'b101) begin
      region_o = 4'(RG_XRAM);
      offset_o = OFFS_W'(addr_i[12:0]);
    end else if (addr_i < OAM_BASE) begin
      // C000-DFFF and echo E000-FDFF share the low 13 bits
      region_o = 4'(RG_WRAM);
      offset_o = OFFS_W'(addr_i[12:0]);
    end else if (addr_i < HOLE_BASE) begin
      region_o = 4'(RG_OAM);
      offset_o = OFFS_W'(addr_i[7:0]);
    end else if (addr_i < IO_BASE) begin
      region_o = 4'(RG_HOLE);
      offset_o = '0;
    end else if (addr_i < HRAM_BASE) begin
      region_o = 4'(RG_IO);
      offset_o = OFFS_W'(addr_i[6:0]);
    end else begin
      region_o = 4'(RG_HRAM);
      offset_o = OFFS_W'(addr_i[6:0]);
    end
  end
endmodule

// File: rtl/mmd_boot_latch.sv
module mmd_boot_latch
  import mmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic              boot_en_o
);
  logic boot_en_q;
  logic kill;

  assign kill = wr_en_i && (addr_i == BOOT_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   boot_en_q <= 1'b1;
    else if (kill) boot_en_q <= 1'b0;
  end

  assign boot_en_o = boot_en_q;

  assert_boot_stays_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_en_q |=> !boot_en_q);
  assert_boot_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == BOOT_OFF) |=> !boot_en_o);
  assert_boot_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_en_q && !(wr_en_i && addr_i == BOOT_OFF)) |=> boot_en_o);
endmodule

// File: rtl/mmd_rdata_mux.sv
module mmd_rdata_mux #(
  parameter int unsigned N      = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N-1:0]             sel_i,
  input  logic [N-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]        data_o
);
  logic [N-1:0][DATA_W-1:0] masked;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g] = data_i[g] & {DATA_W{sel_i[g]}};
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) data_o |= masked[i];
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [15:0]            addr_i,
  input  logic                   wr_en_i,
  input  logic [ROM_BANK_W-1:0]  rom_bank_i,
  input  logic [RAM_BANK_W-1:0]  ram_bank_i,
  input  logic [DATA_W-1:0]      boot_rdata_i,
  input  logic [DATA_W-1:0]      rom_rdata_i,
  input  logic [DATA_W-1:0]      vram_rdata_i,
  input  logic [DATA_W-1:0]      xram_rdata_i,
  input  logic [DATA_W-1:0]      wram_rdata_i,
  input  logic [DATA_W-1:0]      oam_rdata_i,
  input  logic [DATA_W-1:0]      io_rdata_i,
  input  logic [DATA_W-1:0]      hram_rdata_i,
  output logic [9:0]             sel_o,
  output logic [9:0]             we_o,
  output logic [13:0]            offset_o,
  output logic [ROM_BANK_W-1:0]  rom_bank_o,
  output logic [RAM_BANK_W-1:0]  ram_bank_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   boot_en_o
);
  logic [3:0]                          region;
  logic [NUM_REGIONS-1:0]              sel;
  logic [NUM_REGIONS-1:0][DATA_W-1:0]  rd_bus;
  logic [ROM_BANK_W-1:0]               rom_bank_eff;
  logic                                boot_en;

  mmd_boot_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .boot_en_o (boot_en)
  );

  mmd_region_dec u_dec (
    .addr_i    (addr_i),
    .boot_en_i (boot_en),
    .region_o  (region),
    .offset_o  (offset_o)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_sel
    assign sel[r] = (region == 4'(r));
  end

  assign rd_bus[RG_BOOT] = boot_rdata_i;
  assign rd_bus[RG_ROM0] = rom_rdata_i;
  assign rd_bus[RG_ROMX] = rom_rdata_i;
  assign rd_bus[RG_VRAM] = vram_rdata_i;
  assign rd_bus[RG_XRAM] = xram_rdata_i;
  assign rd_bus[RG_WRAM] = wram_rdata_i;
  assign rd_bus[RG_OAM]  = oam_rdata_i;
  assign rd_bus[RG_HOLE] = '0;
  assign rd_bus[RG_IO]   = io_rdata_i;
  assign rd_bus[RG_HRAM] = hram_rdata_i;

  mmd_rdata_mux #(.N(NUM_REGIONS), .DATA_W(DATA_W)) u_mux (
    .sel_i  (sel),
    .data_i (rd_bus),
    .data_o (rdata_o)
  );

  // bank 0 is not reachable through the switchable window
  assign rom_bank_eff = (rom_bank_i == '0) ? ROM_BANK_W'(1) : rom_bank_i;
  assign rom_bank_o   = sel[RG_ROMX] ? rom_bank_eff : '0;
  assign ram_bank_o   = sel[RG_XRAM] ? ram_bank_i : '0;

  assign sel_o     = sel;
  assign we_o      = sel & WRITABLE & {NUM_REGIONS{wr_en_i}};
  assign boot_en_o = boot_en;

  assert_sel_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_o));
  assert_no_rom_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o[RG_BOOT] | we_o[RG_ROM0] | we_o[RG_ROMX] | we_o[RG_HOLE]) == 1'b0);
  assert_we_needs_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> wr_en_i);
  assert_romx_bank_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[RG_ROMX] |-> (rom_bank_o != '0));
  assert_hole_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[RG_HOLE] |-> (rdata_o == '0));
  assert_boot_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[RG_BOOT] |-> boot_en_o);
endmodule

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [6:0]  rom_bank = '0;
  logic [1:0]  ram_bank = '0;
  logic [9:0]  sel, we;
  logic [13:0] offset;
  logic [6:0]  rom_bank_o;
  logic [1:0]  ram_bank_o;
  logic [7:0]  rdata;
  logic        boot_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_map_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr),
    .rom_bank_i(rom_bank), .ram_bank_i(ram_bank),
    .boot_rdata_i(8'hA1), .rom_rdata_i(8'hA2), .vram_rdata_i(8'hA3),
    .xram_rdata_i(8'hA4), .wram_rdata_i(8'hA5), .oam_rdata_i(8'hA6),
    .io_rdata_i(8'hA7), .hram_rdata_i(8'hA8),
    .sel_o(sel), .we_o(we), .offset_o(offset), .rom_bank_o(rom_bank_o),
    .ram_bank_o(ram_bank_o), .rdata_o(rdata), .boot_en_o(boot_en)
  );

  typedef struct {
    string       tag;
    logic [9:0]  sel;
    logic [9:0]  we;
    logic [13:0] off;
    logic [6:0]  rb;
    logic [1:0]  xb;
    logic [7:0]  rd;
    logic        boot;
  } item_t;

  item_t q[$];
  event  sample_ev;
  bit    boot_model = 1'b1;

  // expected values from the requirements
  function automatic item_t predict(input logic [15:0] a, input logic w,
                                    input logic [6:0] rb, input logic [1:0] xb,
                                    input string tag);
    item_t it;
    int    idx;
    int    base;
    it.tag = tag;
    if (boot_model && a <= 16'h00FF) begin idx = 0; base = 0; end
    else if (a <= 16'h3FFF) begin idx = 1; base = 16'h0000; end
    else if (a <= 16'h7FFF) begin idx = 2; base = 16'h4000; end
    else if (a <= 16'h9FFF) begin idx = 3; base = 16'h8000; end
    else if (a <= 16'hBFFF) begin idx = 4; base = 16'hA000; end
    else if (a <= 16'hDFFF) begin idx = 5; base = 16'hC000; end
    else if (a <= 16'hFDFF) begin idx = 5; base = 16'hE000; end
    else if (a <= 16'hFE9F) begin idx = 6; base = 16'hFE00; end
    else if (a <= 16'hFEFF) begin idx = 7; base = int'(a); end
    else if (a <= 16'hFF7F) begin idx = 8; base = 16'hFF00; end
    else begin idx = 9; base = 16'hFF80; end
    it.sel  = 10'(1) << idx;
    it.off  = 14'(int'(a) - base);
    it.we   = (w && !(idx inside {0, 1, 2, 7})) ? it.sel : 10'd0;
    it.rb   = (idx == 2) ? ((rb == 0) ? 7'd1 : rb) : 7'd0;
    it.xb   = (idx == 4) ? xb : 2'd0;
    case (idx)
      0: it.rd = 8'hA1;
      1, 2: it.rd = 8'hA2;
      3: it.rd = 8'hA3;
      4: it.rd = 8'hA4;
      5: it.rd = 8'hA5;
      6: it.rd = 8'hA6;
      7: it.rd = 8'h00;
      8: it.rd = 8'hA7;
      default: it.rd = 8'hA8;
    endcase
    it.boot = boot_model;
    return it;
  endfunction

  task automatic access(input logic [15:0] a, input logic w, input logic [6:0] rb,
                        input logic [1:0] xb, input string tag);
    @(negedge clk);
    addr = a; wr = w; rom_bank = rb; ram_bank = xb;
    q.push_back(predict(a, w, rb, xb, tag));
    -> sample_ev;
    @(posedge clk);
    if (w && a == 16'hFF50) boot_model = 1'b0;
    #1 wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    boot_model = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (q.size() != 0) begin
        item_t e;
        bit    bad;
        e = q.pop_front();
        bad = 0;
        n_tests++;
        if (sel !== e.sel) begin bad = 1;
          $display("FAIL %s sel act=%b exp=%b", e.tag, sel, e.sel); end
        if (we !== e.we) begin bad = 1;
          $display("FAIL %s we act=%b exp=%b", e.tag, we, e.we); end
        if (offset !== e.off) begin bad = 1;
          $display("FAIL %s offset act=%h exp=%h", e.tag, offset, e.off); end
        if (rom_bank_o !== e.rb) begin bad = 1;
          $display("FAIL %s rom_bank act=%0d exp=%0d", e.tag, rom_bank_o, e.rb); end
        if (ram_bank_o !== e.xb) begin bad = 1;
          $display("FAIL %s ram_bank act=%0d exp=%0d", e.tag, ram_bank_o, e.xb); end
        if (rdata !== e.rd) begin bad = 1;
          $display("FAIL %s rdata act=%h exp=%h", e.tag, rdata, e.rd); end
        if (boot_en !== e.boot) begin bad = 1;
          $display("FAIL %s boot_en act=%b exp=%b", e.tag, boot_en, e.boot); end
        if (bad) n_fail++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // reset state and boot overlay
    access(16'h0000, 0, 7'd0, 2'd0, "R1 R8 reset boot low");
    access(16'h00FF, 0, 7'd0, 2'd0, "R1 boot top");
    access(16'h0100, 0, 7'd0, 2'd0, "R2 rom0 above overlay");
    access(16'h3FFF, 0, 7'd3, 2'd0, "R2 rom0 top");
    // switchable rom
    access(16'h4000, 0, 7'd5, 2'd0, "R3 romx bank5");
    access(16'h7FFF, 0, 7'd0, 2'd0, "R3 romx bank0->1");
    access(16'h5A5A, 0, 7'd127, 2'd0, "R3 romx bank127");
    // vram / xram
    access(16'h8000, 0, 7'd0, 2'd2, "R4 vram low");
    access(16'h9FFF, 0, 7'd0, 2'd2, "R4 vram top");
    access(16'hA000, 0, 7'd0, 2'd3, "R4 xram bank3");
    access(16'hBFFF, 0, 7'd0, 2'd1, "R4 xram top");
    // wram and echo
    access(16'hC000, 0, 7'd0, 2'd0, "R5 wram low");
    access(16'hDFFF, 0, 7'd0, 2'd0, "R5 wram top");
    access(16'hE000, 0, 7'd0, 2'd0, "R5 echo low");
    access(16'hFDFF, 0, 7'd0, 2'd0, "R5 echo top");
    // oam and hole
    access(16'hFE00, 0, 7'd0, 2'd0, "R6 oam low");
    access(16'hFE9F, 0, 7'd0, 2'd0, "R6 oam top");
    access(16'hFEA0, 0, 7'd0, 2'd0, "R6 hole low");
    access(16'hFEFF, 0, 7'd0, 2'd0, "R6 hole top");
    // io and hram
    access(16'hFF00, 0, 7'd0, 2'd0, "R7 io low");
    access(16'hFF7F, 0, 7'd0, 2'd0, "R7 io top");
    access(16'hFF80, 0, 7'd0, 2'd0, "R7 hram low");
    access(16'hFFFF, 0, 7'd0, 2'd0, "R7 hram top R11");
    // write strobes (R9 one-hot checked on every item)
    access(16'h0010, 1, 7'd0, 2'd0, "R10 write boot");
    access(16'h1234, 1, 7'd0, 2'd0, "R10 write rom0");
    access(16'h5000, 1, 7'd2, 2'd0, "R10 write romx");
    access(16'hFEB0, 1, 7'd0, 2'd0, "R10 write hole");
    access(16'h8001, 1, 7'd0, 2'd0, "R10 write vram");
    access(16'hA123, 1, 7'd0, 2'd2, "R10 write xram");
    access(16'hC123, 1, 7'd0, 2'd0, "R10 write wram");
    access(16'hE123, 1, 7'd0, 2'd0, "R10 write echo");
    access(16'hFE10, 1, 7'd0, 2'd0, "R10 write oam");
    access(16'hFF10, 1, 7'd0, 2'd0, "R10 write io");
    access(16'hFF90, 1, 7'd0, 2'd0, "R10 write hram");
    // boot latch
    access(16'hFF4F, 1, 7'd0, 2'd0, "R8 write neighbour");
    access(16'h0000, 0, 7'd0, 2'd0, "R8 overlay kept");
    access(16'hFF50, 1, 7'd0, 2'd0, "R8 disable write");
    access(16'h0000, 0, 7'd0, 2'd0, "R8 R2 overlay gone");
    access(16'h00FF, 0, 7'd0, 2'd0, "R8 R2 overlay gone top");
    access(16'hFF50, 1, 7'd0, 2'd0, "R8 second disable");
    access(16'h0050, 0, 7'd0, 2'd0, "R8 stays off");
    do_reset();
    access(16'h0080, 0, 7'd0, 2'd0, "R8 R1 reset restores");
    @(negedge clk);
    #2;
    finish_run();
  end
endmodule